// File: doc/BRIEF.md
# Atomic-Alias Control Register Bank

This block is a bank of 32-bit control and status registers behind a simple APB-style slave port. Every register is reachable at a word-aligned base address. Most registers also have three companion addresses that change only chosen bits. A write to one of these addresses sets, clears or inverts the bits that are high in the write data. Software can therefore change single bits without a read-modify-write sequence and without racing another agent.

The bank holds a read/write control register with aliases and a read/write mode register without aliases. It also holds a read-only status register fed from hardware inputs and a write-only command register with aliases. Last comes an array of identical read/write channel registers, placed at a fixed stride, each with its own aliases. Illegal or unmapped accesses raise the error response, leave every register as it was and read back zero.

Top module: `regbank_top`

## Requirements
- R1: While `rst` is high and after its release, all writable registers (control, mode, command, channels) are zero and `pslverr` is low.
- R2: A write at a register's base address (low address nibble 0x0) replaces the whole register. A read there returns the current value.
- R3: A write at base+0x4 leaves the register equal to its old value OR the write data.
- R4: A write at base+0x8 leaves the register equal to its old value AND the inverse of the write data.
- R5: A write at base+0xC leaves the register equal to its old value XOR the write data.
- R6: A read at any of a register's four addresses returns its current value and changes nothing.
- R7: The mode register at 0x010 has no aliases. Accesses at 0x014, 0x018 and 0x01C raise the error response and leave it unchanged.
- R8: The status register at 0x020..0x02C is read-only. A read returns `status_in` as sampled on the clock edge before the access phase. Any write to it raises the error response.
- R9: The command register at 0x030..0x03C is write-only and supports all four write kinds. Any read of it raises the error response and returns zero.
- R10: Channel i sits at 0x100 + i*0x10 for i below `NCHAN`, with its own four addresses. A write to one channel leaves all other registers unchanged.
- R11: An unmapped address raises the error response, returns zero and changes no register. This covers a channel slot at or beyond `NCHAN`, a gap in the map, or an address with bits [1:0] not zero.
- R12: Outside the access phase (`psel` and `penable` both high), `prdata` is zero, `pslverr` is low and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Error response for the current access |
| status_in | input | 32 | Hardware status sampled into the read-only register |
| ctrl_o | output | 32 | Control register contents |
| mode_o | output | 32 | Mode register contents |
| kick_o | output | 32 | Command register contents |
| chan_o | output | NCHAN*32 | Channel registers, channel i in bits [32*i+31:32*i] |

## Verification
The assertions assume that the master follows the two-phase protocol: a setup cycle with `psel` high and `penable` low, then exactly one access cycle. They also assume that address, direction and write data are held across both phases. The bench drives every transfer through one task that holds these signals from setup through access and returns to idle afterwards, so the protocol assumption always holds. `status_in` is changed only while the bus is idle, at least one edge before a read, so the sampled value the bench expects is unambiguous.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;

    localparam int DW    = 32;
    localparam int IDX_W = 8;

    // fixed register slots, one slot = 16 bytes
    localparam int SLOT_CTRL = 0;
    localparam int SLOT_MODE = 1;
    localparam int SLOT_STAT = 2;
    localparam int SLOT_KICK = 3;

    typedef enum logic [1:0] {
        ALIAS_PLAIN = 2'd0,
        ALIAS_SET   = 2'd1,
        ALIAS_CLR   = 2'd2,
        ALIAS_TOG   = 2'd3
    } alias_e;

    typedef enum logic [1:0] {
        PERM_RW = 2'd0,
        PERM_RO = 2'd1,
        PERM_WO = 2'd2
    } perm_e;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_CTRL = 3'd1,
        TGT_MODE = 3'd2,
        TGT_STAT = 3'd3,
        TGT_KICK = 3'd4,
        TGT_CHAN = 3'd5
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        alias_e           kind;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic logic [DW-1:0] alias_apply(
        input logic [DW-1:0] old_v,
        input logic [DW-1:0] wd,
        input alias_e        kind
    );
        logic [DW-1:0] r;
        case (kind)
            ALIAS_SET: r = old_v | wd;
            ALIAS_CLR: r = old_v & ~wd;
            ALIAS_TOG: r = old_v ^ wd;
            default:   r = wd;
        endcase
        return r;
    endfunction

    function automatic perm_e perm_of(input tgt_e t);
        perm_e p;
        case (t)
            TGT_STAT: p = PERM_RO;
            TGT_KICK: p = PERM_WO;
            default:  p = PERM_RW;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/regbank_decode.sv
`timescale 1ns/1ps
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NCHAN     = 4,
    parameter int CHAN_BASE = 256,
    parameter int CHAN_STEP = 16
) (
    input  logic [ADDR_W-1:0] paddr,
    output dec_t              dec
);
    localparam int SLOT_W     = ADDR_W - 4;
    localparam int CHAN_SLOT0 = CHAN_BASE / 16;
    localparam int CHAN_SSTEP = CHAN_STEP / 16;

    logic [SLOT_W-1:0] slot;
    alias_e            kind;
    logic              aligned;

    assign slot    = paddr[ADDR_W-1:4];
    assign kind    = alias_e'(paddr[3:2]);
    assign aligned = (paddr[1:0] == 2'b00);

    always_comb begin
        dec      = '0;
        dec.tgt  = TGT_NONE;
        dec.kind = kind;
        if (aligned) begin
            if (slot == SLOT_W'(SLOT_CTRL))      dec.tgt = TGT_CTRL;
            else if (slot == SLOT_W'(SLOT_MODE)) dec.tgt = (kind == ALIAS_PLAIN) ? TGT_MODE : TGT_NONE;
            else if (slot == SLOT_W'(SLOT_STAT)) dec.tgt = TGT_STAT;
            else if (slot == SLOT_W'(SLOT_KICK)) dec.tgt = TGT_KICK;
            for (int i = 0; i < NCHAN; i++) begin
                if (slot == SLOT_W'(CHAN_SLOT0 + i * CHAN_SSTEP)) begin
                    dec.tgt = TGT_CHAN;
                    dec.idx = IDX_W'(i);
                end
            end
        end
    end

    initial begin
        a_r10_step_ok: assert (CHAN_STEP % 16 == 0 && CHAN_STEP >= 16);
    end

endmodule

// File: rtl/regbank_cell.sv
`timescale 1ns/1ps
module regbank_cell
    import regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  alias_e        kind,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= alias_apply(q, wd, kind);
    end

    a_r2_plain_write: assert property (@(posedge clk) disable iff (rst)
        we && kind == ALIAS_PLAIN |=> q == $past(wd));
    a_r3_set_bits: assert property (@(posedge clk) disable iff (rst)
        we && kind == ALIAS_SET |=> q == ($past(q) | $past(wd)));
    a_r4_clear_bits: assert property (@(posedge clk) disable iff (rst)
        we && kind == ALIAS_CLR |=> q == ($past(q) & ~$past(wd)));
    a_r5_toggle_bits: assert property (@(posedge clk) disable iff (rst)
        we && kind == ALIAS_TOG |=> q == ($past(q) ^ $past(wd)));
    a_r6_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/regbank_top.sv
`timescale 1ns/1ps
module regbank_top
    import regbank_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NCHAN     = 4,
    parameter int CHAN_BASE = 256,
    parameter int CHAN_STEP = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [DW-1:0]       pwdata,
    output logic [DW-1:0]       prdata,
    output logic                pslverr,
    input  logic [DW-1:0]       status_in,
    output logic [DW-1:0]       ctrl_o,
    output logic [DW-1:0]       mode_o,
    output logic [DW-1:0]       kick_o,
    output logic [NCHAN*DW-1:0] chan_o
);
    dec_t          dec;
    perm_e         perm;
    logic          access, illegal, wr_ok, rd_ok;
    logic          we_ctrl, we_mode, we_kick;
    logic [NCHAN-1:0] we_chan;
    logic [DW-1:0] stat_q;
    logic [DW-1:0] chan_q [NCHAN];
    logic [DW-1:0] rmux;

    regbank_decode #(
        .ADDR_W(ADDR_W), .NCHAN(NCHAN),
        .CHAN_BASE(CHAN_BASE), .CHAN_STEP(CHAN_STEP)
    ) u_dec (
        .paddr(paddr),
        .dec  (dec)
    );

    assign access  = psel && penable;
    assign perm    = perm_of(dec.tgt);
    assign illegal = (dec.tgt == TGT_NONE)
                   || (pwrite  && perm == PERM_RO)
                   || (!pwrite && perm == PERM_WO);
    assign wr_ok   = access && pwrite && !illegal;
    assign rd_ok   = access && !pwrite && !illegal;

    assign we_ctrl = wr_ok && dec.tgt == TGT_CTRL;
    assign we_mode = wr_ok && dec.tgt == TGT_MODE;
    assign we_kick = wr_ok && dec.tgt == TGT_KICK;

    regbank_cell u_ctrl (
        .clk(clk), .rst(rst), .we(we_ctrl), .kind(dec.kind), .wd(pwdata), .q(ctrl_o));
    regbank_cell u_mode (
        .clk(clk), .rst(rst), .we(we_mode), .kind(ALIAS_PLAIN), .wd(pwdata), .q(mode_o));
    regbank_cell u_kick (
        .clk(clk), .rst(rst), .we(we_kick), .kind(dec.kind), .wd(pwdata), .q(kick_o));

    for (genvar g = 0; g < NCHAN; g++) begin : g_chan
        assign we_chan[g] = wr_ok && dec.tgt == TGT_CHAN && dec.idx == IDX_W'(g);
        regbank_cell u_cell (
            .clk(clk), .rst(rst), .we(we_chan[g]), .kind(dec.kind),
            .wd(pwdata), .q(chan_q[g]));
        assign chan_o[g*DW +: DW] = chan_q[g];
    end

    // hardware status is sampled every edge
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= status_in;
    end

    always_comb begin
        rmux = '0;
        case (dec.tgt)
            TGT_CTRL: rmux = ctrl_o;
            TGT_MODE: rmux = mode_o;
            TGT_STAT: rmux = stat_q;
            TGT_CHAN: begin
                for (int i = 0; i < NCHAN; i++)
                    if (dec.idx == IDX_W'(i)) rmux = chan_q[i];
            end
            default:  rmux = '0;
        endcase
    end

    assign prdata  = rd_ok ? rmux : '0;
    assign pslverr = access && illegal;

    a_r11_error_keeps_state: assert property (@(posedge clk) disable iff (rst)
        pslverr |=> $stable(ctrl_o) && $stable(mode_o) && $stable(kick_o) && $stable(chan_o));
    a_r11_error_reads_zero: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> prdata == '0);
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !(psel && penable) |-> !pslverr && prdata == '0);
    a_r12_idle_no_update: assert property (@(posedge clk) disable iff (rst)
        !(psel && penable) |=> $stable(ctrl_o) && $stable(mode_o) && $stable(kick_o) && $stable(chan_o));
    a_r10_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({we_ctrl, we_mode, we_kick, we_chan}));
    a_r1_reset_clean: assert property (@(posedge clk)
        $past(rst) |-> ctrl_o == '0 && mode_o == '0 && kick_o == '0 && chan_o == '0);

endmodule

// File: tb/sim_regbank_top.sv
`timescale 1ns/1ps
module sim_regbank_top;

    localparam int ADDR_W = 12;
    localparam int NCHAN  = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0]   paddr = '0;
    logic [31:0]         pwdata = '0;
    logic [31:0]         prdata;
    logic                pslverr;
    logic [31:0]         status_in = '0;
    logic [31:0]         ctrl_o, mode_o, kick_o;
    logic [NCHAN*32-1:0] chan_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // reference model state
    logic [31:0] m_ctrl = '0, m_mode = '0, m_kick = '0;
    logic [31:0] m_chan [NCHAN];

    always #2.5 clk = ~clk;

    regbank_top #(.ADDR_W(ADDR_W), .NCHAN(NCHAN)) u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
        .status_in(status_in), .ctrl_o(ctrl_o), .mode_o(mode_o),
        .kick_o(kick_o), .chan_o(chan_o));

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check(req, "ctrl_o", ctrl_o, m_ctrl);
        check(req, "mode_o", mode_o, m_mode);
        check(req, "kick_o", kick_o, m_kick);
        for (int i = 0; i < NCHAN; i++)
            check(req, $sformatf("chan_o[%0d]", i), chan_o[i*32 +: 32], m_chan[i]);
    endtask

    function automatic logic [31:0] apply(input int kind, input logic [31:0] o,
                                          input logic [31:0] d);
        if (kind == 1) return o | d;
        if (kind == 2) return o & ~d;
        if (kind == 3) return o ^ d;
        return d;
    endfunction

    // one two-phase transfer; model decides error, data and the new state
    task automatic xfer(input string req, input bit w, input int addr,
                        input logic [31:0] d);
        int off, kind, base, tgt, idx;
        bit err;
        logic [31:0] exp_rd;
        off  = addr % 16;
        kind = off / 4;
        base = addr - off;
        tgt  = 0; idx = 0;
        if (addr % 4 == 0) begin
            if (base == 'h000) tgt = 1;
            else if (base == 'h010 && off == 0) tgt = 2;
            else if (base == 'h020) tgt = 3;
            else if (base == 'h030) tgt = 4;
            else if (base >= 'h100 && (base - 'h100) / 16 < NCHAN) begin
                tgt = 5; idx = (base - 'h100) / 16;
            end
        end
        err = (tgt == 0) || (w && tgt == 3) || (!w && tgt == 4);
        exp_rd = '0;
        if (!w && !err) begin
            case (tgt)
                1: exp_rd = m_ctrl;
                2: exp_rd = m_mode;
                3: exp_rd = status_in;
                5: exp_rd = m_chan[idx];
                default: exp_rd = '0;
            endcase
        end
        psel = 1'b1; penable = 1'b0; pwrite = w;
        paddr = ADDR_W'(addr); pwdata = d;
        #1;
        check("R12", "setup pslverr", {31'b0, pslverr}, 32'd0);
        check("R12", "setup prdata", prdata, 32'd0);
        @(negedge clk);
        check_state("R12");
        penable = 1'b1;
        #1;
        check(req, $sformatf("pslverr @%03h", addr), {31'b0, pslverr}, {31'b0, err});
        check(req, $sformatf("prdata @%03h", addr), prdata, exp_rd);
        @(negedge clk);
        if (w && !err) begin
            case (tgt)
                1: m_ctrl = apply(kind, m_ctrl, d);
                2: m_mode = d;
                4: m_kick = apply(kind, m_kick, d);
                5: m_chan[idx] = apply(kind, m_chan[idx], d);
                default: ;
            endcase
        end
        check_state(req);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #1;
        check("R12", "idle pslverr", {31'b0, pslverr}, 32'd0);
        @(negedge clk);
        check_state("R12");
    endtask

    initial begin
        for (int i = 0; i < NCHAN; i++) m_chan[i] = '0;
        repeat (3) @(negedge clk);
        check_state("R1");
        check("R1", "pslverr in reset", {31'b0, pslverr}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1");

        // R2 plain write and read back
        xfer("R2", 1, 'h000, 32'hA5A5_0F0F);
        xfer("R2", 0, 'h000, 0);
        // R3, R4, R5 bit aliases
        xfer("R3", 1, 'h004, 32'h0000_F0F0);
        xfer("R4", 1, 'h008, 32'hA500_0003);
        xfer("R5", 1, 'h00C, 32'hFFFF_0000);
        // R6 reads at every alias
        xfer("R6", 0, 'h004, 0);
        xfer("R6", 0, 'h008, 0);
        xfer("R6", 0, 'h00C, 0);
        // R7 register without aliases
        xfer("R7", 1, 'h010, 32'h0000_1234);
        xfer("R7", 1, 'h014, 32'hFFFF_FFFF);
        xfer("R7", 1, 'h018, 32'hFFFF_FFFF);
        xfer("R7", 1, 'h01C, 32'hFFFF_FFFF);
        xfer("R7", 0, 'h014, 0);
        xfer("R7", 0, 'h010, 0);
        // R8 read-only status
        status_in = 32'hDEAD_BEEF;
        @(negedge clk);
        xfer("R8", 0, 'h020, 0);
        status_in = 32'h0123_4567;
        @(negedge clk);
        xfer("R8", 0, 'h02C, 0);
        xfer("R8", 1, 'h020, 32'h1);
        xfer("R8", 1, 'h024, 32'h1);
        // R9 write-only command register
        xfer("R9", 1, 'h030, 32'h0000_000F);
        xfer("R9", 1, 'h034, 32'h0000_00F0);
        xfer("R9", 1, 'h038, 32'h0000_0003);
        xfer("R9", 1, 'h03C, 32'h8000_0001);
        xfer("R9", 0, 'h030, 0);
        xfer("R9", 0, 'h034, 0);
        // R10 channel array
        for (int i = 0; i < NCHAN; i++)
            xfer("R10", 1, 'h100 + 16*i, 32'h1111_1111 * (i + 1));
        xfer("R10", 1, 'h124, 32'h8000_0000);
        xfer("R10", 1, 'h128, 32'h0000_0033);
        xfer("R10", 1, 'h12C, 32'h00FF_00FF);
        for (int i = 0; i < NCHAN; i++)
            xfer("R10", 0, 'h100 + 16*i + 4*(i % 4), 0);
        // R11 unmapped, beyond array, misaligned
        xfer("R11", 1, 'h100 + 16*NCHAN, 32'hFFFF_FFFF);
        xfer("R11", 0, 'h100 + 16*NCHAN, 0);
        xfer("R11", 1, 'h200, 32'hFFFF_FFFF);
        xfer("R11", 0, 'h0F0, 0);
        xfer("R11", 1, 'h002, 32'hFFFF_FFFF);
        xfer("R11", 0, 'h001, 0);
        // mixed traffic over the map
        for (int n = 0; n < 80; n++) begin
            int pick, a;
            pick = int'($urandom_range(0, 4 + NCHAN));
            if (pick < 5) a = 16 * pick;
            else          a = 'h100 + 16 * (pick - 5);
            a = a + 4 * int'($urandom_range(0, 3));
            status_in = $urandom;
            @(negedge clk);
            xfer("R10", $urandom_range(0, 1) == 1, a, $urandom);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule